// File: doc/BRIEF.md
# Translation Table Update Engine

This block owns one I/O translation table held in on-chip RAM and carries out the commands that change or inspect it. A command names the table by a 64-bit identifier, gives a bus address, and carries a value (an entry, or the base of an entry list in system memory) and a count. The engine turns each bus address into a table slot using the configured window offset and page size. It checks every slot against the configured entry count and writes slots one at a time. After every write it emits a record that a downstream translation cache uses to invalidate or refresh its copy.

Four operations exist: store one entry, fetch one entry, fill a run of consecutive pages with one value, and load a run of consecutive pages from a list of 64-bit entries in memory. The list is read through a one-outstanding request/response port. Multi-entry operations stop at the first slot that fails. Slots written before the failure keep their new values.

After reset the engine sweeps the RAM to zero before it takes its first command.

Top module: `xlt_table_engine`

## Requirements
- R1: After reset `busy` is high while every slot is cleared. `busy` then falls, and every slot reads back as zero.
- R2: A command is rejected with status 1 (parameter error), and nothing is written, when any of bits 63:32 of `cmd_table_id` is set, when bits 31:0 differ from `cfg_table_id`, or when `cfg_enable` is low.
- R3: The bus address is first ANDed with the page mask, ~((1<<`cfg_page_shift`)-1). The slot is then (address − `cfg_bus_offset`) >> `cfg_page_shift`. Op 0 stores `cmd_value` there, and any address within the same page reaches the same slot.
- R4: A slot index greater than or equal to `cfg_entry_count` gives status 1 with no write. This includes addresses below the window offset.
- R5: Fill (op 2) is rejected up front with status 1 when `cmd_count` exceeds `cfg_entry_count`. Otherwise it writes `cmd_value` to `cmd_count` consecutive pages starting at the masked address.
- R6: List load (op 3) is rejected with status 1 when `cmd_count` exceeds 512 or when bits 11:0 of the list base (`cmd_value`) are not zero.
- R7: List load fetches entry i from list base + 8·i. `mem_rdata` bits [8k+7:8k] hold the byte at address +k, and the entry is taken big-endian (the byte at the lowest address is the most significant). The entry is written to the i-th consecutive page.
- R8: A fill or list load stops at the first out-of-range slot with status 1. Slots already written in that command keep their new values.
- R9: Each write raises `ntf_valid` for one cycle. The record carries the window-relative page address, the entry ANDed with the page mask, the in-page offset mask, and the entry's bits 1:0 as the permission code.
- R10: Fetch (op 1) returns the raw 64-bit slot on `rd_entry` with status 0.
- R11: A fill or list load with `cmd_count` = 0 completes with status 0 and no write and no notification.
- R12: A command is accepted when `cmd_valid` is high and `busy` is low. `busy` stays high from then until the cycle in which `done` pulses for one cycle with `status` valid. Status 0 means success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Table configured and usable |
| cfg_table_id | input | 32 | Identifier of this table |
| cfg_bus_offset | input | DW | Bus address of window start |
| cfg_page_shift | input | SH_W | log2 of the page size |
| cfg_entry_count | input | IDX_W+1 | Number of valid slots (at most DEPTH) |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 store, 1 fetch, 2 fill, 3 list load |
| cmd_table_id | input | 64 | Table identifier of the command |
| cmd_addr | input | DW | Bus address of first page |
| cmd_value | input | DW | Entry value, or list base for op 3 |
| cmd_count | input | CNT_W | Page count for ops 2 and 3 |
| busy | output | 1 | Command or reset clear in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 success, 1 parameter error |
| rd_entry | output | DW | Slot value returned by op 1 |
| ntf_valid | output | 1 | Notification record valid |
| ntf_iova | output | DW | Window-relative page address |
| ntf_xlate | output | DW | Entry with offset bits cleared |
| ntf_offmask | output | DW | In-page offset mask |
| ntf_perm | output | 2 | Permission code from entry bits 1:0 |
| mem_req | output | 1 | List entry read request pulse |
| mem_addr | output | DW | List entry address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | DW | Read response, byte k in lane k |

## Verification
The bench aims at the edges of the window. It writes just past the last slot and just below the window offset; a design that compared with greater-than, or failed to treat the wrapped subtraction as out of range, would corrupt a slot. It runs fill and list load across the window end and checks that exactly the in-range slots changed and that exactly that many notifications appeared; an engine that checked the whole run up front, or went on after the failure, would show a different slot image or notification count. It feeds list entries with distinct bytes, so a missing or wrong byte reversal shows in the readback. Identifiers with only high bits set, zero-length runs and unaligned list bases cover the rejection and early-success paths, where a wrong engine would write a slot or report the wrong status.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

  typedef enum logic [1:0] {
    OP_STORE = 2'd0,
    OP_FETCH = 2'd1,
    OP_FILL  = 2'd2,
    OP_LIST  = 2'd3
  } xlt_op_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_PARAM = 2'd1
  } xlt_status_e;

  typedef enum logic [2:0] {
    S_CLEAR,
    S_IDLE,
    S_CHECK,
    S_STEP,
    S_FETCH,
    S_LWRITE,
    S_RDWAIT
  } xlt_state_e;

  // lane k holds the byte at address +k; result is most-significant-first
  function automatic logic [63:0] be_lanes_to_word(input logic [63:0] lanes);
    logic [63:0] w;
    for (int b = 0; b < 8; b++) begin
      w[8*b +: 8] = lanes[56-8*b +: 8];
    end
    return w;
  endfunction

endpackage

// File: rtl/xlt_index_calc.sv
module xlt_index_calc #(
  parameter int DW    = 64,
  parameter int IDX_W = 6,
  parameter int SH_W  = 6
) (
  input  logic [DW-1:0]    page_addr,
  input  logic [DW-1:0]    bus_offset,
  input  logic [SH_W-1:0]  page_shift,
  input  logic [IDX_W:0]   entry_count,
  output logic [DW-1:0]    rel_addr,
  output logic [IDX_W-1:0] slot,
  output logic             out_of_range
);
  logic [DW-1:0] full_idx;
  logic [DW-1:0] limit;

  always_comb begin
    rel_addr     = page_addr - bus_offset;
    full_idx     = rel_addr >> page_shift;
    limit        = {{(DW-IDX_W-1){1'b0}}, entry_count};
    out_of_range = (full_idx >= limit);
    slot         = full_idx[IDX_W-1:0];
  end
endmodule

// File: rtl/xlt_entry_ram.sv
module xlt_entry_ram #(
  parameter int DW    = 64,
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/xlt_notify_out.sv
module xlt_notify_out #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [DW-1:0] rel_addr,
  input  logic [DW-1:0] entry,
  input  logic [DW-1:0] page_mask,
  output logic          ntf_valid,
  output logic [DW-1:0] ntf_iova,
  output logic [DW-1:0] ntf_xlate,
  output logic [DW-1:0] ntf_offmask,
  output logic [1:0]    ntf_perm
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ntf_valid   <= 1'b0;
      ntf_iova    <= '0;
      ntf_xlate   <= '0;
      ntf_offmask <= '0;
      ntf_perm    <= 2'd0;
    end else begin
      ntf_valid <= fire;
      if (fire) begin
        ntf_iova    <= rel_addr & page_mask;
        ntf_xlate   <= entry & page_mask;
        ntf_offmask <= ~page_mask;
        ntf_perm    <= entry[1:0];
      end
    end
  end
endmodule

// File: rtl/xlt_table_engine.sv
module xlt_table_engine
  import xlt_pkg::*;
#(
  parameter int DW          = 64,
  parameter int DEPTH       = 64,
  parameter int CNT_W       = 16,
  parameter int LIST_MAX    = 512,
  parameter int LIST_ALIGN  = 12,
  localparam int IDX_W      = $clog2(DEPTH),
  localparam int SH_W       = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_enable,
  input  logic [31:0]      cfg_table_id,
  input  logic [DW-1:0]    cfg_bus_offset,
  input  logic [SH_W-1:0]  cfg_page_shift,
  input  logic [IDX_W:0]   cfg_entry_count,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [63:0]      cmd_table_id,
  input  logic [DW-1:0]    cmd_addr,
  input  logic [DW-1:0]    cmd_value,
  input  logic [CNT_W-1:0] cmd_count,
  output logic             busy,
  output logic             done,
  output logic [1:0]       status,
  output logic [DW-1:0]    rd_entry,
  output logic             ntf_valid,
  output logic [DW-1:0]    ntf_iova,
  output logic [DW-1:0]    ntf_xlate,
  output logic [DW-1:0]    ntf_offmask,
  output logic [1:0]       ntf_perm,
  output logic             mem_req,
  output logic [DW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] LIST_CAP  = CNT_W'(LIST_MAX);
  localparam logic [CNT_W-1:0] ONE_LEFT  = CNT_W'(1);

  xlt_state_e       state_q;
  xlt_op_e          op_q;
  logic [63:0]      id_q;
  logic [DW-1:0]    cur_addr_q;
  logic [DW-1:0]    val_q;
  logic [DW-1:0]    fetched_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] list_i_q;
  logic [IDX_W-1:0] clr_q;

  logic [DW-1:0]    page_mask;
  logic [DW-1:0]    page_size;
  logic [DW-1:0]    rel_addr;
  logic [IDX_W-1:0] slot;
  logic             oob;
  logic             id_bad;
  logic             fill_too_long;
  logic             list_bad;

  logic             ram_we;
  logic [IDX_W-1:0] ram_waddr;
  logic [DW-1:0]    ram_wdata;
  logic [DW-1:0]    ram_rdata;
  logic             write_fire;

  always_comb begin
    page_size = {{(DW-1){1'b0}}, 1'b1} << cfg_page_shift;
    page_mask = ~(page_size - {{(DW-1){1'b0}}, 1'b1});
  end

  xlt_index_calc #(.DW(DW), .IDX_W(IDX_W), .SH_W(SH_W)) u_index (
    .page_addr    (cur_addr_q),
    .bus_offset   (cfg_bus_offset),
    .page_shift   (cfg_page_shift),
    .entry_count  (cfg_entry_count),
    .rel_addr     (rel_addr),
    .slot         (slot),
    .out_of_range (oob)
  );

  // parameter checks evaluated in S_CHECK on latched command fields
  always_comb begin
    id_bad        = (id_q[63:32] != 32'd0) || !cfg_enable ||
                    (id_q[31:0] != cfg_table_id);
    fill_too_long = cnt_q > {{(CNT_W-IDX_W-1){1'b0}}, cfg_entry_count};
    list_bad      = (cnt_q > LIST_CAP) || (val_q[LIST_ALIGN-1:0] != '0);
  end

  // RAM write port arbitration: reset sweep, direct value, or fetched entry
  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = slot;
    ram_wdata = val_q;
    unique case (state_q)
      S_CLEAR: begin
        ram_we    = 1'b1;
        ram_waddr = clr_q;
        ram_wdata = '0;
      end
      S_STEP: begin
        ram_we = !oob && (op_q == OP_STORE || op_q == OP_FILL);
      end
      S_LWRITE: begin
        ram_we    = 1'b1;
        ram_wdata = fetched_q;
      end
      default: ram_we = 1'b0;
    endcase
    write_fire = ram_we && (state_q != S_CLEAR);
  end

  xlt_entry_ram #(.DW(DW), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (slot),
    .rdata (ram_rdata)
  );

  xlt_notify_out #(.DW(DW)) u_notify (
    .clk         (clk),
    .rst         (rst),
    .fire        (write_fire),
    .rel_addr    (rel_addr),
    .entry       (ram_wdata),
    .page_mask   (page_mask),
    .ntf_valid   (ntf_valid),
    .ntf_iova    (ntf_iova),
    .ntf_xlate   (ntf_xlate),
    .ntf_offmask (ntf_offmask),
    .ntf_perm    (ntf_perm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_CLEAR;
      op_q       <= OP_STORE;
      id_q       <= '0;
      cur_addr_q <= '0;
      val_q      <= '0;
      fetched_q  <= '0;
      cnt_q      <= '0;
      left_q     <= '0;
      list_i_q   <= '0;
      clr_q      <= '0;
      busy       <= 1'b1;
      done       <= 1'b0;
      status     <= ST_OK;
      rd_entry   <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
    end else begin
      done    <= 1'b0;
      mem_req <= 1'b0;
      unique case (state_q)
        S_CLEAR: begin
          clr_q <= clr_q + 1'b1;
          if (clr_q == LAST_SLOT) begin
            state_q <= S_IDLE;
            busy    <= 1'b0;
          end
        end
        S_IDLE: begin
          if (cmd_valid) begin
            op_q       <= xlt_op_e'(cmd_op);
            id_q       <= cmd_table_id;
            cur_addr_q <= cmd_addr & page_mask;
            val_q      <= cmd_value;
            cnt_q      <= cmd_count;
            left_q     <= cmd_count;
            list_i_q   <= '0;
            busy       <= 1'b1;
            state_q    <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (id_bad ||
              (op_q == OP_FILL && fill_too_long) ||
              (op_q == OP_LIST && list_bad)) begin
            done <= 1'b1; busy <= 1'b0; status <= ST_PARAM; state_q <= S_IDLE;
          end else if ((op_q == OP_FILL || op_q == OP_LIST) && cnt_q == '0) begin
            done <= 1'b1; busy <= 1'b0; status <= ST_OK; state_q <= S_IDLE;
          end else begin
            state_q <= S_STEP;
          end
        end
        S_STEP: begin
          if (oob) begin
            done <= 1'b1; busy <= 1'b0; status <= ST_PARAM; state_q <= S_IDLE;
          end else begin
            unique case (op_q)
              OP_STORE: begin
                done <= 1'b1; busy <= 1'b0; status <= ST_OK; state_q <= S_IDLE;
              end
              OP_FETCH: state_q <= S_RDWAIT;
              OP_FILL: begin
                cur_addr_q <= cur_addr_q + page_size;
                left_q     <= left_q - 1'b1;
                if (left_q == ONE_LEFT) begin
                  done <= 1'b1; busy <= 1'b0; status <= ST_OK; state_q <= S_IDLE;
                end
              end
              OP_LIST: begin
                mem_req  <= 1'b1;
                mem_addr <= val_q + {{(DW-CNT_W-3){1'b0}}, list_i_q, 3'b000};
                state_q  <= S_FETCH;
              end
              default: state_q <= S_IDLE;
            endcase
          end
        end
        S_FETCH: begin
          if (mem_rvalid) begin
            fetched_q <= be_lanes_to_word(mem_rdata);
            state_q   <= S_LWRITE;
          end
        end
        S_LWRITE: begin
          cur_addr_q <= cur_addr_q + page_size;
          left_q     <= left_q - 1'b1;
          list_i_q   <= list_i_q + 1'b1;
          if (left_q == ONE_LEFT) begin
            done <= 1'b1; busy <= 1'b0; status <= ST_OK; state_q <= S_IDLE;
          end else begin
            state_q <= S_STEP;
          end
        end
        S_RDWAIT: begin
          rd_entry <= ram_rdata;
          done <= 1'b1; busy <= 1'b0; status <= ST_OK; state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlt_engine_checks.sv
module xlt_engine_checks #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          busy,
  input logic          done,
  input logic [1:0]    status,
  input logic          ntf_valid,
  input logic [DW-1:0] ntf_iova,
  input logic [DW-1:0] ntf_xlate,
  input logic [DW-1:0] ntf_offmask,
  input logic          mem_req,
  input logic [DW-1:0] mem_addr
);
  a_r12_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r12_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy) |=> busy);

  a_r12_status_code: assert property (@(posedge clk) disable iff (rst)
    done |-> (status == 2'd0 || status == 2'd1));

  a_r9_record_aligned: assert property (@(posedge clk) disable iff (rst)
    ntf_valid |-> ((ntf_xlate & ntf_offmask) == '0 && (ntf_iova & ntf_offmask) == '0));

  a_r9_record_from_command: assert property (@(posedge clk) disable iff (rst)
    ntf_valid |-> $past(busy));

  a_r7_fetch_word_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[2:0] == 3'd0));

  a_r7_single_request: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  a_r7_request_while_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
endmodule

bind xlt_table_engine xlt_engine_checks #(.DW(DW)) u_engine_checks (.*);

// File: tb/test_xlt_table_engine.sv
module test_xlt_table_engine;
  localparam int DW = 64;
  localparam logic [63:0] TID  = 64'h0000_0A5C;
  localparam logic [63:0] OFF  = 64'h8000_0000;
  localparam logic [63:0] LBAS = 64'h4000_0000;

  typedef struct packed {
    logic [1:0]  op;
    logic [63:0] id;
    logic [63:0] addr;
    logic [63:0] val;
    logic [15:0] cnt;
    logic [1:0]  st;
    logic [7:0]  nn;
    logic        rdchk;
    logic [63:0] rd;
  } vec_t;

  // R2/R3/R4/R5/R6/R10/R11 vectors
  localparam vec_t VEC [13] = '{
    '{2'd0, TID, OFF + 64'h5234, 64'h0000_0012_3456_7003, 16'd0, 2'd0, 8'd1, 1'b0, 64'd0},
    '{2'd1, TID, OFF + 64'h5FFF, 64'd0, 16'd0, 2'd0, 8'd0, 1'b1, 64'h0000_0012_3456_7003},
    '{2'd0, 64'h1_0000_0A5C, OFF + 64'h6000, 64'h7, 16'd0, 2'd1, 8'd0, 1'b0, 64'd0},
    '{2'd0, 64'h0A5D, OFF + 64'h6000, 64'h7, 16'd0, 2'd1, 8'd0, 1'b0, 64'd0},
    '{2'd0, TID, OFF + 64'h28000, 64'h7, 16'd0, 2'd1, 8'd0, 1'b0, 64'd0},
    '{2'd0, TID, OFF - 64'h1000, 64'h7, 16'd0, 2'd1, 8'd0, 1'b0, 64'd0},
    '{2'd1, TID, OFF + 64'h28000, 64'd0, 16'd0, 2'd1, 8'd0, 1'b0, 64'd0},
    '{2'd2, TID, OFF, 64'h9, 16'd41, 2'd1, 8'd0, 1'b0, 64'd0},
    '{2'd3, TID, OFF, LBAS, 16'd513, 2'd1, 8'd0, 1'b0, 64'd0},
    '{2'd3, TID, OFF, LBAS + 64'h8, 16'd1, 2'd1, 8'd0, 1'b0, 64'd0},
    '{2'd2, TID, OFF, 64'h9, 16'd0, 2'd0, 8'd0, 1'b0, 64'd0},
    '{2'd3, TID, OFF, LBAS, 16'd0, 2'd0, 8'd0, 1'b0, 64'd0},
    '{2'd1, TID, OFF + 64'h6000, 64'd0, 16'd0, 2'd0, 8'd0, 1'b1, 64'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [63:0]   cmd_table_id = '0;
  logic [DW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_value = '0;
  logic [15:0]   cmd_count = '0;
  logic          busy, done, ntf_valid, mem_req;
  logic [1:0]    status, ntf_perm;
  logic [DW-1:0] rd_entry, ntf_iova, ntf_xlate, ntf_offmask, mem_addr;
  logic          mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  xlt_table_engine i_xlt_table_engine (
    .clk(clk), .rst(rst),
    .cfg_enable(1'b1), .cfg_table_id(TID[31:0]), .cfg_bus_offset(OFF),
    .cfg_page_shift(6'd12), .cfg_entry_count(7'd40),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_table_id(cmd_table_id),
    .cmd_addr(cmd_addr), .cmd_value(cmd_value), .cmd_count(cmd_count),
    .busy(busy), .done(done), .status(status), .rd_entry(rd_entry),
    .ntf_valid(ntf_valid), .ntf_iova(ntf_iova), .ntf_xlate(ntf_xlate),
    .ntf_offmask(ntf_offmask), .ntf_perm(ntf_perm),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;

  function automatic logic [63:0] swap8(input logic [63:0] v);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = v[56-8*b +: 8];
    return r;
  endfunction

  function automatic logic [63:0] list_val(input int k);
    return 64'h1122_3344_5566_7701 + (64'(k) << 20) + 64'(k);
  endfunction

  // memory model: lane-ordered words, response two cycles after request
  int pend = 0;
  logic [63:0] pend_addr = '0;
  always @(negedge clk) begin
    mem_rvalid <= 1'b0;
    if (pend == 1) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= swap8(list_val(int'(pend_addr[5:3])));
    end
    if (pend > 0) pend <= pend - 1;
    if (mem_req) begin
      pend      <= 2;
      pend_addr <= mem_addr;
    end
  end

  int ntf_cnt = 0;
  logic [63:0] l_iova, l_xlate, l_mask;
  logic [1:0]  l_perm;
  always @(negedge clk) begin
    if (ntf_valid) begin
      ntf_cnt <= ntf_cnt + 1;
      l_iova  <= ntf_iova;
      l_xlate <= ntf_xlate;
      l_mask  <= ntf_offmask;
      l_perm  <= ntf_perm;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [1:0]  got_st;
  logic [63:0] got_rd;
  int          got_n;

  task automatic run(input logic [1:0] op, input logic [63:0] id, input logic [63:0] addr,
                     input logic [63:0] val, input logic [15:0] cnt);
    int base;
    @(negedge clk);
    base = ntf_cnt;
    cmd_valid = 1'b1; cmd_op = op; cmd_table_id = id;
    cmd_addr = addr; cmd_value = val; cmd_count = cnt;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy && !done, "R12 busy after accept", {62'd0, busy, done}, 64'd2);
    while (!done) @(negedge clk);
    got_st = status;
    got_rd = rd_entry;
    @(negedge clk);
    got_n = ntf_cnt - base;
  endtask

  task automatic read_slot(input int idx, input logic [63:0] exp, input string req);
    run(2'd1, TID, OFF + (64'(idx) << 12), 64'd0, 16'd0);
    check(got_st == 2'd0 && got_rd == exp, req, got_rd, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R1 busy during clear", {63'd0, busy}, 64'd1);
    while (busy) @(negedge clk);
    check(status == 2'd0, "R1 reset status", {62'd0, status}, 64'd0);
    read_slot(0, 64'd0, "R1 slot 0 cleared");
    read_slot(39, 64'd0, "R1 slot 39 cleared");

    for (int i = 0; i < 13; i++) begin
      run(VEC[i].op, VEC[i].id, VEC[i].addr, VEC[i].val, VEC[i].cnt);
      check(got_st == VEC[i].st, $sformatf("R2/R3/R4/R5/R6/R11 vector %0d status", i),
            {62'd0, got_st}, {62'd0, VEC[i].st});
      check(got_n == int'(VEC[i].nn), $sformatf("R9/R11 vector %0d notify count", i),
            64'(got_n), 64'(VEC[i].nn));
      if (VEC[i].rdchk)
        check(got_rd == VEC[i].rd, $sformatf("R10 vector %0d entry", i), got_rd, VEC[i].rd);
    end

    // R5 fill of slots 10..12, R9 record of the last write
    run(2'd2, TID, OFF + 64'hA123, 64'h0000_00AB_CDEF_1002, 16'd3);
    check(got_st == 2'd0 && got_n == 3, "R5 fill status/count", 64'(got_n), 64'd3);
    check(l_iova == 64'hC000, "R9 iova", l_iova, 64'hC000);
    check(l_xlate == 64'h0000_00AB_CDEF_1000, "R9 xlate", l_xlate, 64'h0000_00AB_CDEF_1000);
    check(l_mask == 64'hFFF, "R9 offset mask", l_mask, 64'hFFF);
    check(l_perm == 2'd2, "R9 perm", {62'd0, l_perm}, 64'd2);
    read_slot(10, 64'h0000_00AB_CDEF_1002, "R5 slot 10");
    read_slot(12, 64'h0000_00AB_CDEF_1002, "R5 slot 12");
    read_slot(13, 64'd0, "R5 slot 13 untouched");

    // R8 fill crossing the window end
    run(2'd2, TID, OFF + 64'h26000, 64'h55_0001, 16'd5);
    check(got_st == 2'd1 && got_n == 2, "R8 fill stop", {got_st, 62'(got_n)}, {2'd1, 62'd2});
    read_slot(39, 64'h55_0001, "R8 fill kept slot 39");

    // R7 list load into slots 20..22
    run(2'd3, TID, OFF + 64'h14000, LBAS, 16'd3);
    check(got_st == 2'd0 && got_n == 3, "R7 list status/count", 64'(got_n), 64'd3);
    check(l_perm == list_val(2)[1:0], "R9 list perm", {62'd0, l_perm}, {62'd0, list_val(2)[1:0]});
    read_slot(20, list_val(0), "R7 slot 20");
    read_slot(21, list_val(1), "R7 slot 21");
    read_slot(22, list_val(2), "R7 slot 22");

    // R8 list load crossing the window end
    run(2'd3, TID, OFF + 64'h26000, LBAS + 64'h1000, 16'd4);
    check(got_st == 2'd1 && got_n == 2, "R8 list stop", {got_st, 62'(got_n)}, {2'd1, 62'd2});
    read_slot(38, list_val(0), "R8 list kept slot 38");
    read_slot(39, list_val(1), "R8 list kept slot 39");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule